// File: doc/BRIEF.md
# Dual Timer/Counter with Four Counting Modes

This block holds two independent 16-bit counting channels. Each channel has a low byte and a high byte and a small configuration nibble. A divide-by-DIV prescaler (twelve by default) turns the oscillator clock into a one-cycle machine-cycle enable. In timer operation a channel steps once per machine cycle. In counter operation it steps once for each falling transition seen on its event pin. A run bit, which can be qualified by a gate pin, starts and stops each channel. This allows a pulse width to be measured directly in hardware.

Software sets up the block over a byte-wide register bus with a write strobe and a combinational read. The bus reaches a mode register, a control register holding run bits and overflow flags, and the four count bytes. A channel can be a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads itself from its high byte. Channel 0 can also be split into two 8-bit counters, and that split takes over channel 1's run bit and flag. Each overflow flag is brought out as an interrupt request.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 00h, both `irq` bits are low and no channel counts.
- R2: In timer operation (C/T=0, GATE=0), a channel whose run bit is 1 advances by exactly one every DIV clocks. With its run bit at 0, its count bytes do not change.
- R3: With GATE=1 a channel advances only while its gate pin, delayed through a two-flop synchronizer, is high. With the pin low the count holds even though the run bit is 1.
- R4: With C/T=1 a channel advances once per falling transition of its event pin, sampled once per machine cycle. A rising edge or a steady level adds nothing.
- R5: Mode 00 counts through the 13-bit value {high[4:0], low}. Counting never changes high[7:5]. The wrap from all ones to zero sets the channel's flag.
- R6: Mode 01 counts through {high, low}. The wrap from FFFFh to 0000h sets the flag, so a preset P sets the flag on machine cycle 10000h−P and not before.
- R7: Mode 10 steps only the low byte. On the FFh wrap it loads the low byte from the high byte, leaves the high byte unchanged, sets the flag and keeps counting.
- R8: Mode 11 on channel 0 makes its low byte an 8-bit counter under channel 0's C/T, GATE, run bit and flag. Its high byte becomes a timer run by channel 1's run bit, and the wrap of that high byte sets channel 1's flag.
- R9: Channel 1 in mode 11 holds its count as if its run bit were 0.
- R10: An overflow flag stays at 1 until software writes 0 to it. Each `irq` bit always equals its channel's flag.
- R11: A bus write to a count byte wins over a hardware step of that byte in the same clock. A write to the control register wins over a hardware flag set in the same clock.
- R12: Register addresses:
  - 0 = mode. Channel 0 uses bits 3..0 and channel 1 uses bits 7..4, each nibble ordered GATE, C/T, M1, M0 from MSB down.
  - 1 = control. Bit 4 is run0, bit 5 is flag0, bit 6 is run1, bit 7 is flag1. Bits 3..0 read 0.
  - 2 and 3 = channel 0 low and high.
  - 4 and 5 = channel 1 low and high.
  - Reads are combinational and return live values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe, commits on the rising clock edge |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for `addr` |
| eventPin | input | 2 | External event inputs, one per channel |
| gatePin | input | 2 | External gate inputs, one per channel |
| irq | output | 2 | Interrupt requests, equal to the overflow flags |

## Verification
The main stepping function is run from presets chosen to cover distinct cases:
- A mid-range value, which shows plain machine-cycle pacing.
- Presets just below each mode's wrap point, which show which bits take part in the carry: 13 against 16 bits, and the untouched high[7:5].
- A wrap under auto-reload, which separates reload from a plain roll to zero.

Every run starts on a machine-cycle boundary, so each expected value is an exact tick count.

The control inputs are exercised with:
- Gate-pin levels, which separate gating from the run bit.
- Slow event pulses, which separate falling edges from rising edges and steady levels.
- Split-mode traffic, which shows the borrowed run bit and flag acting on channel 0's high byte while channel 1 stays frozen.

Bus writes placed exactly on a tick edge show the priority of software over hardware.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] A_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI1  = 3'd5;

  // Strobes from control to datapath, one clock wide.
  typedef struct packed {
    logic cnt0;    // step channel 0 (whole counter, or low byte when split)
    logic cnt1;    // step channel 1
    logic cntHi0;  // step channel 0 high byte in split mode
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DIV = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  modeReg,
  input  logic [1:0]  runBits,
  input  logic [1:0]  eventPin,
  input  logic [1:0]  gatePin,
  output tmr_strobe_t stb
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc;
  logic          tick;
  logic [1:0]    evMeta, evSync, evPrev, gtMeta, gtSync;
  logic [1:0]    fallEv, en;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else if (presc == LAST) presc <= '0;
    else presc <= presc + 1'b1;
  end
  assign tick = (presc == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evMeta <= '0; evSync <= '0; evPrev <= '0;
      gtMeta <= '0; gtSync <= '0;
    end else begin
      evMeta <= eventPin; evSync <= evMeta;
      gtMeta <= gatePin;  gtSync <= gtMeta;
      if (tick) evPrev <= evSync;
    end
  end

  for (genvar c = 0; c < 2; c++) begin : gEn
    assign fallEv[c] = tick & evPrev[c] & ~evSync[c];
    assign en[c] = runBits[c] & (~modeReg[4*c+3] | gtSync[c])
                 & (modeReg[4*c+2] ? fallEv[c] : tick);
  end

  assign stb.cnt0   = en[0];
  assign stb.cnt1   = en[1] & (modeReg[5:4] != 2'b11);
  assign stb.cntHi0 = tick & runBits[1] & (modeReg[1:0] == 2'b11);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  tmr_strobe_t       stb,
  output logic [7:0]        modeReg,
  output logic [1:0]        runBits,
  output logic [1:0]        flags
);
  logic [7:0] modeQ;
  logic [1:0] runQ, flagQ;
  logic [7:0] loQ [2];
  logic [7:0] hiQ [2];
  logic [1:0] wrapMain;
  logic       splitWrap;

  for (genvar c = 0; c < 2; c++) begin : gCh
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(2 + 2*c);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(3 + 2*c);
    logic [7:0] lo, hi, nLo, nHi;
    logic [1:0] md;
    logic       step, wrap;

    assign md   = modeQ[4*c +: 2];
    assign step = (c == 0) ? stb.cnt0 : stb.cnt1;

    always_comb begin
      nLo  = lo;
      nHi  = hi;
      wrap = 1'b0;
      if (step) begin
        case (md)
          2'b00: begin
            {nHi[4:0], nLo} = {hi[4:0], lo} + 13'd1;
            wrap = &{hi[4:0], lo};
          end
          2'b01: begin
            {nHi, nLo} = {hi, lo} + 16'd1;
            wrap = &{hi, lo};
          end
          2'b10: begin
            nLo  = (&lo) ? hi : lo + 8'd1;
            wrap = &lo;
          end
          default: begin
            nLo  = lo + 8'd1;
            wrap = &lo;
          end
        endcase
      end
      if (c == 0 && stb.cntHi0) nHi = hi + 8'd1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lo <= '0;
        hi <= '0;
      end else begin
        lo <= (wrEn && addr == LO_A) ? wrData : nLo;
        hi <= (wrEn && addr == HI_A) ? wrData : nHi;
      end
    end

    assign loQ[c]      = lo;
    assign hiQ[c]      = hi;
    assign wrapMain[c] = wrap;
  end

  assign splitWrap = stb.cntHi0 & (hiQ[0] == 8'hFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      runQ  <= '0;
      flagQ <= '0;
    end else begin
      if (wrEn && addr == A_MODE) modeQ <= wrData;
      if (wrEn && addr == A_CTRL) begin
        runQ  <= {wrData[6], wrData[4]};
        flagQ <= {wrData[7], wrData[5]};
      end else begin
        if (wrapMain[0])             flagQ[0] <= 1'b1;
        if (wrapMain[1] | splitWrap) flagQ[1] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rdData = modeQ;
      A_CTRL:  rdData = {flagQ[1], runQ[1], flagQ[0], runQ[0], 4'h0};
      A_LO0:   rdData = loQ[0];
      A_HI0:   rdData = hiQ[0];
      A_LO1:   rdData = loQ[1];
      A_HI1:   rdData = hiQ[1];
      default: rdData = 8'h00;
    endcase
  end

  assign modeReg = modeQ;
  assign runBits = runQ;
  assign flags   = flagQ;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int DIV = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic [1:0]        eventPin,
  input  logic [1:0]        gatePin,
  output logic [1:0]        irq
);
  tmr_strobe_t stb;
  logic [7:0]  modeReg;
  logic [1:0]  runBits;
  logic [1:0]  flags;

  tmr_ctrl #(.DIV(DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeReg(modeReg), .runBits(runBits),
    .eventPin(eventPin), .gatePin(gatePin), .stb(stb)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .stb(stb), .modeReg(modeReg), .runBits(runBits),
    .flags(flags)
  );

  assign irq = flags;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              wrFlag0,
  input logic [7:0]        rdData,
  input logic              gate0,
  input logic [1:0]        irq,
  input logic [1:0]        ch0Mode,
  input logic              ch0GateEn,
  input logic [1:0]        ch1Mode,
  input logic [1:0]        runBits,
  input tmr_strobe_t       stb
);
  AST_IRQ_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_CTRL) |-> (rdData[7] == irq[1] && rdData[5] == irq[0])); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq[0]) |-> $past(wrEn && addr == A_CTRL && !wrFlag0)); // R10
  AST_RUN_GATES_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.cnt0 |-> runBits[0]); // R2
  AST_GATE_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cnt0 && ch0GateEn) |-> $past(gate0, 2)); // R3
  AST_SPLIT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntHi0 |-> (ch0Mode == 2'b11 && runBits[1])); // R8
  AST_CH1_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (ch1Mode == 2'b11) |-> !stb.cnt1); // R9
  AST_CTRL_LAYOUT: assert property (@(posedge clk) disable iff (!rstN)
    (addr == A_CTRL) |-> (rdData[3:0] == 4'h0 && rdData[4] == runBits[0]
                          && rdData[6] == runBits[1])); // R12
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrFlag0(wrData[5]),
  .rdData(rdData), .gate0(gatePin[0]), .irq(irq), .ch0Mode(modeReg[1:0]),
  .ch0GateEn(modeReg[3]), .ch1Mode(modeReg[5:4]), .runBits(runBits), .stb(stb)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  localparam int DIV = 12;
  localparam logic [2:0] MODE = 3'd0, CTRL = 3'd1, LO0 = 3'd2, HI0 = 3'd3,
                         LO1 = 3'd4, HI1 = 3'd5;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0, rdData;
  logic [1:0] eventPin = '0, gatePin = '0, irq;
  int edgeN = 0;
  int vectors = 0, miscompares = 0;

  always #4 clk = ~clk;
  always @(posedge clk) if (!rstN) edgeN <= 0; else edgeN <= edgeN + 1;

  tmr_pair #(.DIV(DIV)) u0 (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .eventPin(eventPin), .gatePin(gatePin),
    .irq(irq));

  // mode byte, preset {hi,lo}, ticks, expected {hi,lo}, expected flag0, req
  typedef struct packed {
    logic [7:0] mode; logic [15:0] preset; logic [7:0] ticks;
    logic [15:0] expCnt; logic expFlag; logic [7:0] req;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{8'h01, 16'h30EE, 8'd3, 16'h30F1, 1'b0, 8'd2},  // R2 plain pacing
    '{8'h01, 16'hFFFE, 8'd2, 16'h0000, 1'b1, 8'd6},  // R6 16-bit wrap
    '{8'h01, 16'h00FF, 8'd1, 16'h0100, 1'b0, 8'd6},  // R6 carry
    '{8'h00, 16'hFFFF, 8'd1, 16'hE000, 1'b1, 8'd5},  // R5 wrap keeps hi[7:5]
    '{8'h00, 16'h00FF, 8'd1, 16'h0100, 1'b0, 8'd5},  // R5 carry into hi
    '{8'h02, 16'hA0FE, 8'd3, 16'hA0A1, 1'b1, 8'd7},  // R7 reload then count
    '{8'h02, 16'h5510, 8'd4, 16'h5514, 1'b0, 8'd7},  // R7 no wrap
    '{8'h03, 16'h10FF, 8'd2, 16'h1001, 1'b1, 8'd8}   // R8 split low byte
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; the write commits on the next rising edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic rd16(input logic [2:0] loA, output logic [15:0] v);
    logic [7:0] l, h;
    rd(loA, l); rd(loA + 3'd1, h); v = {h, l};
  endtask

  task automatic waitEdge(input int target);
    while (edgeN < target) @(negedge clk);
  endtask

  // next write commits on an edge that is a multiple of DIV (a tick edge)
  task automatic alignTick();
    while (edgeN % DIV != DIV - 1) @(negedge clk);
  endtask

  initial begin : main
    logic [7:0] v;
    logic [15:0] c16, a16;
    int w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reset reg %0d", a), {8'h0, v}, 16'h0);
    end
    chk("R1 reset irq", {14'h0, irq}, 16'h0);

    // table-driven stepping tests on channel 0
    for (int i = 0; i < NV; i++) begin
      wr(CTRL, 8'h00); wr(MODE, VT[i].mode);
      wr(LO0, VT[i].preset[7:0]); wr(HI0, VT[i].preset[15:8]);
      alignTick(); wr(CTRL, 8'h10); w = edgeN;
      waitEdge(w + DIV * int'(VT[i].ticks));
      rd16(LO0, c16);
      chk($sformatf("R%0d vector %0d count", VT[i].req, i), c16, VT[i].expCnt);
      rd(CTRL, v);
      chk($sformatf("R%0d vector %0d flag0", VT[i].req, i), {15'h0, v[5]}, {15'h0, VT[i].expFlag});
    end

    // R10 flag sticky, irq follows, cleared only by software
    wr(CTRL, 8'h20);  // run0 off, flag0 set by write
    repeat (40) @(negedge clk);
    chk("R10 flag held", {14'h0, irq}, 16'h1);
    wr(CTRL, 8'h00);
    chk("R10 flag cleared", {14'h0, irq}, 16'h0);

    // R6 preset FFF0 sets flag on the 16th machine cycle, not the 15th
    wr(MODE, 8'h01); wr(LO0, 8'hF0); wr(HI0, 8'hFF);
    alignTick(); wr(CTRL, 8'h10); w = edgeN;
    waitEdge(w + DIV * 15);
    rd(CTRL, v); chk("R6 no flag at 15", {15'h0, v[5]}, 16'h0);
    waitEdge(w + DIV * 16);
    rd(CTRL, v); chk("R6 flag at 16", {15'h0, v[5]}, 16'h1);

    // R2 run bit clear holds the count
    wr(CTRL, 8'h00); wr(LO0, 8'h34); wr(HI0, 8'h12);
    repeat (4 * DIV) @(negedge clk);
    rd16(LO0, c16); chk("R2 stopped holds", c16, 16'h1234);

    // R3 gate pin qualifies run bit
    wr(MODE, 8'h09); wr(LO0, 8'h00); wr(HI0, 8'h00);
    alignTick(); wr(CTRL, 8'h10); w = edgeN;
    waitEdge(w + DIV * 3);
    rd16(LO0, c16); chk("R3 gate low holds", c16, 16'h0000);
    gatePin[0] = 1'b1;
    waitEdge(w + DIV * 4);
    rd16(LO0, a16);
    waitEdge(w + DIV * 8);
    rd16(LO0, c16); chk("R3 gate high counts", c16 - a16, 16'd4);
    gatePin[0] = 1'b0;
    waitEdge(w + DIV * 9);
    rd16(LO0, a16);
    waitEdge(w + DIV * 13);
    rd16(LO0, c16); chk("R3 gate dropped holds", c16, a16);
    wr(CTRL, 8'h00);

    // R4 event counting on channel 1 (C/T=1, mode 01)
    wr(MODE, 8'h50); wr(LO1, 8'h00); wr(HI1, 8'h00); wr(CTRL, 8'h40);
    for (int p = 0; p < 3; p++) begin
      eventPin[1] = 1'b1; repeat (3 * DIV) @(negedge clk);
      rd16(LO1, c16); chk($sformatf("R4 rising edge %0d adds nothing", p), c16, 16'(p));
      eventPin[1] = 1'b0; repeat (3 * DIV) @(negedge clk);
      rd16(LO1, c16); chk($sformatf("R4 falling edge %0d counted", p), c16, 16'(p + 1));
    end
    wr(CTRL, 8'h00);

    // R8 / R9 split mode: channel 1 run bit drives channel 0 high byte
    wr(MODE, 8'h33); wr(LO0, 8'h40); wr(HI0, 8'hFE);
    wr(LO1, 8'h05); wr(HI1, 8'h07);
    alignTick(); wr(CTRL, 8'h40); w = edgeN;
    waitEdge(w + DIV * 2);
    rd16(LO0, c16); chk("R8 split high wraps, low idle", c16, 16'h0040);
    rd(CTRL, v); chk("R8 split sets flag1", {15'h0, v[7]}, 16'h1);
    chk("R8 irq1 raised", {14'h0, irq}, 16'h2);
    rd16(LO1, c16); chk("R9 channel 1 frozen", c16, 16'h0705);
    wr(CTRL, 8'h00);

    // R11 byte write wins over a same-edge step
    wr(MODE, 8'h01); wr(LO0, 8'h10); wr(HI0, 8'h00); wr(CTRL, 8'h10);
    alignTick(); wr(LO0, 8'h77);
    rd(LO0, v); chk("R11 byte write wins", {8'h0, v}, 16'h0077);

    // R11 control write wins over a same-edge flag set
    wr(CTRL, 8'h00); wr(LO0, 8'hFF); wr(HI0, 8'hFF);
    alignTick(); wr(CTRL, 8'h10); w = edgeN;
    waitEdge(w + DIV - 1);
    wr(CTRL, 8'h10);
    rd(CTRL, v); chk("R11 control write beats flag", {15'h0, v[5]}, 16'h0);
    rd16(LO0, c16); chk("R11 count still wrapped", c16, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule